// File: doc/BRIEF.md
# Block-Transfer Host Register Window

This block gives a host processor a byte-wide, three-register window onto a block-transfer style management mailbox. The host uses the control register to hand over requests and to acknowledge attention flags. It uses the data register to stream request bytes in and response bytes out, and the mask register to manage a level interrupt. Inside the block sit a request buffer and a response buffer, each one parameter deep, together with the busy and attention flags.

On the management side, a message handler is told through a one-cycle strobe that a request is ready. It reads the request bytes by index, writes a response into the response buffer, and then pulses a completion input. A separate message-pending input lets the management side flag unsolicited traffic. The host bus is a single-cycle strobe: reads are combinational from the current state, and a read of the data register consumes its byte at the clock edge.

Top module: `bt_host_regs`

## Requirements
- R1: Only `hostAddr[1:0]` is decoded. Offset 0 is control, 1 is data and 2 is mask, and a read of offset 3 returns 0xFF. A control read returns bit7 management-busy, bit6 host-busy, bit4 message-pending attention and bit3 response attention, with every other bit 0. A mask read returns bit1 pending and bit0 enable, with the upper bits 0.
- R2: After reset, all flags, counters and buffer bytes are zero, `irqOut` and `reqReady` are 0, and control and mask both read 0x00.
- R3: A control write with a 1 in bit3 clears response attention. A 1 in bit4 clears message-pending attention. A 1 in bit6 inverts host-busy. A 0 in any of these bits leaves that flag alone.
- R4: A control write with bit2 set makes management-busy 1, and makes `reqReady` 1 for exactly the following cycle.
- R5: A data write stores the byte at index `inCount` only while `inCount` is below the depth (64). `inCount` counts up on every data write and saturates at 255, so an overrun stays visible. A control write with bit0 set returns `inCount` to 0. `inRdData` shows the stored byte at `inRdAddr`.
- R6: A data read returns the next response byte and advances the read position. When the position reaches the response length, both return to zero. A read with nothing left returns 0xFF. A control write with bit1 set rewinds the position to 0.
- R7: A `rspDone` pulse loads the response length (capped at the depth) and rewinds the position. It clears management-busy and sets response attention. If the interrupt is enabled and not yet pending, it also makes the interrupt pending.
- R8: A mask write that changes bit0 from 0 to 1 enables the interrupt, and makes it pending if either attention flag is set. A write that changes bit0 from 1 to 0 disables the interrupt and clears pending. Writing the current enable value does not change enable.
- R9: A mask write with bit1 set clears a pending interrupt.
- R10: `smsAttnIn` acts only on a change. On a rise it sets message-pending attention, and makes the interrupt pending when `smsIrqAsk` is 1, response attention is clear and the interrupt is enabled. On a fall it clears message-pending attention, and clears pending when response attention is clear.
- R11: `irqOut` is 1 exactly when pending is 1, the `USE_IRQ` parameter is 1 and `irqGlobalEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostEn | input | 1 | Host access strobe, one per cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 2 | Register offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational) |
| reqReady | output | 1 | One-cycle request-ready strobe to the handler |
| inCount | output | 8 | Request byte count, saturating |
| inRdAddr | input | 6 | Handler index into the request buffer |
| inRdData | output | 8 | Request byte at `inRdAddr` |
| rspWrEn | input | 1 | Handler response byte write |
| rspWrAddr | input | 6 | Response byte index |
| rspWrData | input | 8 | Response byte |
| rspDone | input | 1 | Response complete pulse |
| rspLen | input | 7 | Response length in bytes |
| smsAttnIn | input | 1 | Message-pending attention from the management side |
| smsIrqAsk | input | 1 | Request an interrupt on a message-pending rise |
| irqGlobalEn | input | 1 | Global interrupt enable |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
A wrong flag shows on the very next host read of control or mask, and a wrong pending bit also shows at `irqOut` in the same cycle. A corrupted read position or length shows on the next data read, either as a wrong byte or as a 0xFF that appears too early or too late. A lost request byte shows at `inRdData` as soon as the handler looks at that index. Because the bench model is compared on every clock, each of these differences is reported in the first cycle it becomes visible at a port.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Control register bit positions (host software decodes these)
  localparam int CTL_CLR_IN   = 0;
  localparam int CTL_CLR_OUT  = 1;
  localparam int CTL_REQ_GO   = 2;
  localparam int CTL_RSP_ATN  = 3;
  localparam int CTL_SMS_ATN  = 4;
  localparam int CTL_HOST_BSY = 6;
  localparam int CTL_MGT_BSY  = 7;
  // Mask register bit positions
  localparam int MSK_EN   = 0;
  localparam int MSK_PEND = 1;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrIn;
    logic clrOut;
    logic pushIn;
    logic popOut;
  } dpStrobe_t;
endpackage

// File: rtl/bt_msg_datapath.sv
module bt_msg_datapath
  import bt_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        wrByte,
  input  logic              rspWrEn,
  input  logic [ADDR_W-1:0] rspWrAddr,
  input  logic [7:0]        rspWrData,
  input  logic              rspDone,
  input  logic [ADDR_W:0]   rspLen,
  input  logic [ADDR_W-1:0] inRdAddr,
  output logic [CNT_W-1:0]  inCount,
  output logic [7:0]        inRdData,
  output logic [7:0]        outByte,
  output logic              outAvail
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_DEPTH = CNT_W'(DEPTH);
  localparam logic [ADDR_W:0]  LEN_DEPTH = (ADDR_W + 1)'(DEPTH);

  logic [7:0]      inMem  [DEPTH];
  logic [7:0]      outMem [DEPTH];
  logic [ADDR_W:0] outPos, outLen, lenCapped;

  assign lenCapped = (rspLen > LEN_DEPTH) ? LEN_DEPTH : rspLen;
  assign outAvail  = outPos < outLen;
  assign outByte   = outMem[outPos[ADDR_W-1:0]];
  assign inRdData  = inMem[inRdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCount <= '0;
      outPos  <= '0;
      outLen  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        inMem[i]  <= '0;
        outMem[i] <= '0;
      end
    end else begin
      if (stb.clrIn) begin
        inCount <= '0;
      end else if (stb.pushIn) begin
        if (inCount < CNT_DEPTH) inMem[inCount[ADDR_W-1:0]] <= wrByte;
        if (inCount != CNT_MAX) inCount <= inCount + CNT_W'(1);
      end
      if (rspWrEn) outMem[rspWrAddr] <= rspWrData;
      if (rspDone) begin
        outLen <= lenCapped;
        outPos <= '0;
      end else if (stb.clrOut) begin
        outPos <= '0;
      end else if (stb.popOut && outAvail) begin
        if (outPos + 1'b1 == outLen) begin
          outPos <= '0;
          outLen <= '0;
        end else begin
          outPos <= outPos + 1'b1;
        end
      end
    end
  end

  AST_OUT_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (outPos < outLen) || (outPos == '0 && outLen == '0)); // R6
  AST_CLR_IN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrIn |=> inCount == '0); // R5
endmodule

// File: rtl/bt_ctrl_flags.sv
module bt_ctrl_flags
  import bt_pkg::*;
#(
  parameter bit USE_IRQ = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostEn,
  input  logic       hostWr,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic [7:0] outByte,
  input  logic       outAvail,
  input  logic       rspDone,
  input  logic       smsAttnIn,
  input  logic       smsIrqAsk,
  input  logic       irqGlobalEn,
  output dpStrobe_t  stb,
  output logic [7:0] hostRdata,
  output logic       reqReady,
  output logic       irqOut
);
  logic rspAtn, smsAtn, hostBusy, mgtBusy, irqEn, irqPend, smsPrev;
  logic nRspAtn, nSmsAtn, nHostBusy, nMgtBusy, nIrqEn, nIrqPend, reqNext;
  logic ctlWr, mskWr;
  wire  unusedWdBits = hostWdata[5] ^ hostWdata[7];

  assign ctlWr = hostEn && hostWr && hostAddr == OFS_CTRL;
  assign mskWr = hostEn && hostWr && hostAddr == OFS_MASK;

  always_comb begin
    nRspAtn   = rspAtn;
    nSmsAtn   = smsAtn;
    nHostBusy = hostBusy;
    nMgtBusy  = mgtBusy;
    nIrqEn    = irqEn;
    nIrqPend  = irqPend;
    reqNext   = 1'b0;
    stb       = '0;
    // host access first
    if (hostEn && hostWr) begin
      case (hostAddr)
        OFS_CTRL: begin
          stb.clrIn  = hostWdata[CTL_CLR_IN];
          stb.clrOut = hostWdata[CTL_CLR_OUT];
          if (hostWdata[CTL_RSP_ATN])  nRspAtn   = 1'b0;
          if (hostWdata[CTL_SMS_ATN])  nSmsAtn   = 1'b0;
          if (hostWdata[CTL_HOST_BSY]) nHostBusy = ~hostBusy;
          if (hostWdata[CTL_REQ_GO]) begin
            nMgtBusy = 1'b1;
            reqNext  = 1'b1;
          end
        end
        OFS_DATA: stb.pushIn = 1'b1;
        OFS_MASK: begin
          if (hostWdata[MSK_EN] != irqEn) begin
            if (hostWdata[MSK_EN]) begin
              if (rspAtn || smsAtn) nIrqPend = 1'b1;
              nIrqEn = 1'b1;
            end else begin
              nIrqPend = 1'b0;
              nIrqEn   = 1'b0;
            end
          end
          if (hostWdata[MSK_PEND] && nIrqPend) nIrqPend = 1'b0;
        end
        default: ;
      endcase
    end
    if (hostEn && !hostWr && hostAddr == OFS_DATA) stb.popOut = outAvail;
    // then response completion
    if (rspDone) begin
      nMgtBusy = 1'b0;
      nRspAtn  = 1'b1;
      if (!nIrqPend && nIrqEn) nIrqPend = 1'b1;
    end
    // then message-pending input edges
    if (smsAttnIn != smsPrev) begin
      if (smsAttnIn) begin
        nSmsAtn = 1'b1;
        if (smsIrqAsk && !nRspAtn && nIrqEn) nIrqPend = 1'b1;
      end else begin
        nSmsAtn = 1'b0;
        if (!nRspAtn && nIrqPend) nIrqPend = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAtn   <= 1'b0;
      smsAtn   <= 1'b0;
      hostBusy <= 1'b0;
      mgtBusy  <= 1'b0;
      irqEn    <= 1'b0;
      irqPend  <= 1'b0;
      smsPrev  <= 1'b0;
      reqReady <= 1'b0;
    end else begin
      rspAtn   <= nRspAtn;
      smsAtn   <= nSmsAtn;
      hostBusy <= nHostBusy;
      mgtBusy  <= nMgtBusy;
      irqEn    <= nIrqEn;
      irqPend  <= nIrqPend;
      smsPrev  <= smsAttnIn;
      reqReady <= reqNext;
    end
  end

  always_comb begin
    case (hostAddr)
      OFS_CTRL: hostRdata = {mgtBusy, hostBusy, 1'b0, smsAtn, rspAtn, 3'b000};
      OFS_DATA: hostRdata = outAvail ? outByte : 8'hFF;
      OFS_MASK: hostRdata = {6'b0, irqPend, irqEn};
      default:  hostRdata = 8'hFF;
    endcase
  end

  assign irqOut = irqPend && USE_IRQ && irqGlobalEn;

  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && hostWdata[CTL_REQ_GO] && !rspDone) |=> (reqReady && mgtBusy)); // R4
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqPend |-> irqEn); // R8
  AST_HBUSY_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && hostWdata[CTL_HOST_BSY]) |=> hostBusy != $past(hostBusy)); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (mskWr && !hostWdata[MSK_EN]) |=> !irqPend); // R8
endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
  import bt_pkg::*;
#(
  parameter int   DEPTH   = 64,
  parameter bit   USE_IRQ = 1'b1,
  localparam int  ADDR_W  = $clog2(DEPTH),
  localparam int  CNT_W   = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEn,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              reqReady,
  output logic [CNT_W-1:0]  inCount,
  input  logic [ADDR_W-1:0] inRdAddr,
  output logic [7:0]        inRdData,
  input  logic              rspWrEn,
  input  logic [ADDR_W-1:0] rspWrAddr,
  input  logic [7:0]        rspWrData,
  input  logic              rspDone,
  input  logic [ADDR_W:0]   rspLen,
  input  logic              smsAttnIn,
  input  logic              smsIrqAsk,
  input  logic              irqGlobalEn,
  output logic              irqOut
);
  dpStrobe_t  stb;
  logic [7:0] outByte;
  logic       outAvail;

  bt_ctrl_flags #(.USE_IRQ(USE_IRQ)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .outByte(outByte),
    .outAvail(outAvail), .rspDone(rspDone), .smsAttnIn(smsAttnIn),
    .smsIrqAsk(smsIrqAsk), .irqGlobalEn(irqGlobalEn), .stb(stb),
    .hostRdata(hostRdata), .reqReady(reqReady), .irqOut(irqOut)
  );

  bt_msg_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(hostWdata),
    .rspWrEn(rspWrEn), .rspWrAddr(rspWrAddr), .rspWrData(rspWrData),
    .rspDone(rspDone), .rspLen(rspLen), .inRdAddr(inRdAddr),
    .inCount(inCount), .inRdData(inRdData), .outByte(outByte),
    .outAvail(outAvail)
  );

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqGlobalEn |-> !irqOut); // R11
endmodule

// File: tb/bt_host_regs_tb_top.sv
module bt_host_regs_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostEn = 0, hostWr = 0;
  logic [1:0] hostAddr = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata;
  logic       reqReady;
  logic [7:0] inCount;
  logic [5:0] inRdAddr = 0;
  logic [7:0] inRdData;
  logic       rspWrEn = 0;
  logic [5:0] rspWrAddr = 0;
  logic [7:0] rspWrData = 0;
  logic       rspDone = 0;
  logic [6:0] rspLen = 0;
  logic       smsAttnIn = 0, smsIrqAsk = 0, irqGlobalEn = 1;
  logic       irqOut;

  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bt_host_regs dut_i (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .reqReady(reqReady), .inCount(inCount), .inRdAddr(inRdAddr),
    .inRdData(inRdData), .rspWrEn(rspWrEn), .rspWrAddr(rspWrAddr),
    .rspWrData(rspWrData), .rspDone(rspDone), .rspLen(rspLen),
    .smsAttnIn(smsAttnIn), .smsIrqAsk(smsIrqAsk), .irqGlobalEn(irqGlobalEn),
    .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  int mIn[64], mOut[64];
  int mInCnt, mOutLen, mOutPos;
  bit mRspAtn, mSms, mHb, mBb, mEn, mPend, mReq, mSmsPrev;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mIn[i]) begin mIn[i] = 0; mOut[i] = 0; end
      mInCnt = 0; mOutLen = 0; mOutPos = 0;
      {mRspAtn, mSms, mHb, mBb, mEn, mPend, mReq, mSmsPrev} = '0;
    end else begin
      bit reqN;
      reqN = 0;
      if (hostEn && hostWr) begin
        if (hostAddr == 0) begin
          if (hostWdata[0]) mInCnt = 0;
          if (hostWdata[1]) mOutPos = 0;
          if (hostWdata[3]) mRspAtn = 0;
          if (hostWdata[4]) mSms = 0;
          if (hostWdata[6]) mHb = !mHb;
          if (hostWdata[2]) begin mBb = 1; reqN = 1; end
        end else if (hostAddr == 1) begin
          if (mInCnt < 64) mIn[mInCnt] = hostWdata;
          if (mInCnt < 255) mInCnt++;
        end else if (hostAddr == 2) begin
          if (hostWdata[0] != mEn) begin
            if (hostWdata[0]) begin
              if (mRspAtn || mSms) mPend = 1;
              mEn = 1;
            end else begin
              mPend = 0; mEn = 0;
            end
          end
          if (hostWdata[1] && mPend) mPend = 0;
        end
      end else if (hostEn && hostAddr == 1 && mOutPos < mOutLen) begin
        mOutPos++;
        if (mOutPos == mOutLen) begin mOutPos = 0; mOutLen = 0; end
      end
      if (rspWrEn) mOut[rspWrAddr] = rspWrData;
      if (rspDone) begin
        mOutLen = (rspLen > 64) ? 64 : int'(rspLen);
        mOutPos = 0; mBb = 0; mRspAtn = 1;
        if (!mPend && mEn) mPend = 1;
      end
      if (smsAttnIn != mSmsPrev) begin
        if (smsAttnIn) begin
          mSms = 1;
          if (smsIrqAsk && !mRspAtn && mEn) mPend = 1;
        end else begin
          mSms = 0;
          if (!mRspAtn && mPend) mPend = 0;
        end
      end
      mSmsPrev = smsAttnIn;
      mReq = reqN;
    end
  end

  function automatic int modelRead(input int a);
    case (a)
      0: return {mBb, mHb, 1'b0, mSms, mRspAtn, 3'b000};
      1: return (mOutPos < mOutLen) ? mOut[mOutPos] : 'hFF;
      2: return {6'b0, mPend, mEn};
      default: return 'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled mid-low-phase before the consuming edge
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      check("R11 irqOut vs model", irqOut, int'(mPend && irqGlobalEn));
      check("R4 reqReady vs model", reqReady, int'(mReq));
      check("R5 inCount vs model", inCount, mInCnt);
      check("R5 inRdData vs model", inRdData, mIn[inRdAddr]);
      if (hostEn && !hostWr)
        check(hostAddr == 1 ? "R6 data read vs model" : "R1 reg read vs model",
              hostRdata, modelRead(hostAddr));
    end
  end

  // ---------------- stimulus tasks (called at negedge) ----------------
  task automatic wr(input int a, input int d);
    hostEn = 1; hostWr = 1; hostAddr = a[1:0]; hostWdata = d[7:0];
    @(negedge clk);
    hostEn = 0; hostWr = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    hostEn = 1; hostWr = 0; hostAddr = a[1:0];
    #2 check(tag, hostRdata, exp);
    @(negedge clk);
    hostEn = 0;
  endtask

  task automatic rspW(input int a, input int d);
    rspWrEn = 1; rspWrAddr = a[5:0]; rspWrData = d[7:0];
    @(negedge clk);
    rspWrEn = 0;
  endtask

  task automatic rspFinish(input int len);
    rspDone = 1; rspLen = len[6:0];
    @(negedge clk);
    rspDone = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R2 irqOut after reset", irqOut, 0);
    check("R2 reqReady after reset", reqReady, 0);
    check("R2 inCount after reset", inCount, 0);
    @(negedge clk);
    rd(0, 'h00, "R2 control after reset");
    rd(2, 'h00, "R2 mask after reset");
    rd(3, 'hFF, "R1 undefined offset");
    rd(1, 'hFF, "R6 empty data read");
    // host busy toggle
    wr(0, 'h40); rd(0, 'h40, "R3 host busy set");
    wr(0, 'h40); rd(0, 'h00, "R3 host busy toggled back");
    // request bytes
    wr(1, 'h04); wr(1, 'h18); wr(1, 'h01); wr(1, 'h36); wr(1, 'h55);
    #1 check("R5 count after five", inCount, 5);
    inRdAddr = 3;
    #1 check("R5 stored byte", inRdData, 'h36);
    @(negedge clk);
    wr(0, 'h04);
    check("R4 strobe high", reqReady, 1);
    @(negedge clk);
    check("R4 strobe one cycle", reqReady, 0);
    rd(0, 'h80, "R4 management busy");
    // clear and overrun
    wr(0, 'h01);
    check("R5 count cleared", inCount, 0);
    for (int i = 0; i < 66; i++) wr(1, i + 1);
    check("R5 overrun count", inCount, 66);
    inRdAddr = 63;
    #1 check("R5 last slot kept", inRdData, 64);
    inRdAddr = 0;
    #1 check("R5 first slot", inRdData, 1);
    @(negedge clk);
    // response
    rspW(0, 'hAA); rspW(1, 'hBB); rspW(2, 'hCC);
    rspFinish(3);
    rd(0, 'h08, "R7 busy cleared, attention set");
    rd(2, 'h00, "R7 no pending while disabled");
    rd(1, 'hAA, "R6 byte0"); rd(1, 'hBB, "R6 byte1");
    wr(0, 'h02);
    rd(1, 'hAA, "R6 rewound byte0"); rd(1, 'hBB, "R6 byte1");
    rd(1, 'hCC, "R6 byte2"); rd(1, 'hFF, "R6 drained");
    // interrupt enable
    wr(2, 'h01); rd(2, 'h03, "R8 enable with attention");
    check("R11 irq raised", irqOut, 1);
    irqGlobalEn = 0;
    #1 check("R11 global gate", irqOut, 0);
    irqGlobalEn = 1;
    @(negedge clk);
    wr(2, 'h03); rd(2, 'h01, "R9 pending cleared");
    check("R9 irq lowered", irqOut, 0);
    wr(2, 'h02); rd(2, 'h00, "R8 disabled");
    wr(2, 'h01); rd(2, 'h03, "R8 re-enable raises");
    wr(2, 'h00); rd(2, 'h00, "R8 disable clears pending");
    wr(0, 'h08); rd(0, 'h00, "R3 attention cleared");
    wr(2, 'h01); rd(2, 'h01, "R8 enable without attention");
    wr(2, 'h01); rd(2, 'h01, "R8 same enable value");
    // message-pending input
    smsIrqAsk = 1; smsAttnIn = 1;
    @(negedge clk);
    rd(0, 'h10, "R10 rise sets flag"); rd(2, 'h03, "R10 rise raises pending");
    wr(2, 'h03); rd(2, 'h01, "R9 clear pending");
    smsAttnIn = 0;
    @(negedge clk);
    rd(0, 'h00, "R10 fall clears flag"); rd(2, 'h01, "R10 fall no pending");
    smsIrqAsk = 0; smsAttnIn = 1;
    @(negedge clk);
    rd(2, 'h01, "R10 rise without ask"); rd(0, 'h10, "R10 flag set");
    wr(2, 'h00); wr(2, 'h01); rd(2, 'h03, "R8 enable with message attention");
    smsAttnIn = 0;
    @(negedge clk);
    rd(2, 'h01, "R10 fall lowers pending"); rd(0, 'h00, "R10 flag cleared");
    // response with interrupt enabled
    rspW(0, 'h11);
    rspFinish(1);
    rd(2, 'h03, "R7 completion raises pending");
    rd(0, 'h08, "R7 attention");
    check("R11 irq on completion", irqOut, 1);
    rd(1, 'h11, "R6 single byte"); rd(1, 'hFF, "R6 drained again");
    // oversize length capped
    rspFinish(100);
    for (int i = 0; i < 64; i++)
      rd(1, i == 0 ? 'h11 : i == 1 ? 'hBB : i == 2 ? 'hCC : 0, "R7 capped response byte");
    rd(1, 'hFF, "R7 cap at depth");
    done = 1;
    summary();
    $finish;
  end
endmodule